// File: doc/BRIEF.md
# Programmable Four-Input Logic Cell

This block is the elementary programmable element of a configurable logic fabric. It has four logic inputs and two outputs. Its logic function is not fixed: it is read out of two eight-entry truth tables held in configuration bits, with three of the inputs acting as the table address. A single storage flip-flop sits beside the tables, and each output can show either the live table result or the stored bit.

The fourth input has two configured uses. In enable mode it gates the flip-flop, so the cell behaves as two independent 3-input functions plus a register with a load enable. In select mode it chooses between the two tables, so the pair acts as one arbitrary 4-input function and the flip-flop loads on every clock. All configuration bits come from an external configuration store and are expected to stay still while the cell runs. A software model that evaluates the programmed truth tables predicts every output exactly.

Top module: `cfg_logic_cell`

## Requirements
- R1: With `cfg_merge`=0 and `cfg_out_reg[0]`=0, `cell_out[0]` equals `cfg_tbl_lo[idx]` in the same cycle, where idx = {sig_in[2], sig_in[1], sig_in[0]} (sig_in[0] is the least significant address bit).
- R2: With `cfg_merge`=0 and `cfg_out_reg[1]`=0, `cell_out[1]` equals `cfg_tbl_hi[idx]` in the same cycle.
- R3: With `cfg_merge`=1, every output whose `cfg_out_reg` bit is 0 equals `cfg_tbl_hi[idx]` when sig_in[3]=1 and `cfg_tbl_lo[idx]` when sig_in[3]=0.
- R4: When `cfg_out_reg[k]`=1, `cell_out[k]` shows the flip-flop state; the other output keeps its table result.
- R5: With `cfg_merge`=0, a rising clock edge loads the flip-flop with `cfg_tbl_lo[idx]` only when sig_in[3]=1; with sig_in[3]=0 it holds its value.
- R6: With `cfg_merge`=1, every rising clock edge loads the flip-flop with the merged 4-input result of R3, whatever the value of sig_in[3].
- R7: `rst`=1 at a rising edge clears the flip-flop to 0 (the default `RST_VAL`), taking priority over any load.
- R8: While `cfg_ff_off`=1 the flip-flop is held at 0 at every edge, whatever the inputs and tables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage flip-flop |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| sig_in | input | SEL_W+1 (4) | Logic inputs; bits 2..0 address the tables, bit 3 is enable or extra select |
| cfg_tbl_lo | input | 2^SEL_W (8) | Truth table for the low half / first function |
| cfg_tbl_hi | input | 2^SEL_W (8) | Truth table for the high half / second function |
| cfg_merge | input | 1 | 0: bit 3 is flip-flop enable; 1: bit 3 selects between tables |
| cfg_out_reg | input | 2 | Per output: 1 shows flip-flop state, 0 shows table result |
| cfg_ff_off | input | 1 | Holds the flip-flop in reset while set |
| cell_out | output | 2 | Cell outputs |

## Verification
The assertions check on every clock edge that unregistered outputs agree with the addressed table bit in split mode, that both unregistered outputs agree in merged mode, that a registered output tracks the flip-flop, and that the flip-flop loads, holds or stays cleared as its enable and hold-off bits say. What they cannot show is that the truth tables are fully and correctly addressed across many table contents, which needs the bench's exhaustive sweep of all sixteen input codes over a dozen table pairs in both modes. Sequences such as the enable gating over a run of inputs, reset priority over a pending load, and release from the hold-off are shown only by the bench's scenarios.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;
   localparam int unsigned LC_NUM_OUT = 2;

   // Role of the uppermost logic input
   typedef enum logic {
      DM_ENABLE = 1'b0,   // gates the flip-flop load
      DM_SELECT = 1'b1    // picks between the two tables
   } d_mode_e;

   // Raw results of the two lookups
   typedef struct packed {
      logic hi;
      logic lo;
   } lut_pair_t;
endpackage

// File: rtl/lcell_lut.sv
`timescale 1ns/1ps
// One lookup table: picks a stored bit addressed by the select lines.
module lcell_lut #(
   parameter int unsigned SEL_W    = 3,
   parameter bit          TREE_MUX = 1'b1,
   localparam int unsigned DEPTH   = 1 << SEL_W,
   localparam int unsigned NODES   = 2 * DEPTH - 1
) (
   input  logic [DEPTH-1:0] tbl,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_out
);
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("lcell_lut: SEL_W must lie in 1..6");
   end

   if (TREE_MUX) begin : g_tree
      // Binary mux tree in heap order: node n has children 2n+1 (sel=0) and 2n+2 (sel=1).
      logic [NODES-1:0] node;

      for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
         assign node[DEPTH-1+i] = tbl[i];
      end

      for (genvar k = 0; k < SEL_W; k++) begin : g_level
         for (genvar j = 0; j < (1 << k); j++) begin : g_node
            localparam int unsigned N = (1 << k) - 1 + j;
            assign node[N] = sel[SEL_W-1-k] ? node[2*N+2] : node[2*N+1];
         end
      end

      assign bit_out = node[0];
   end else begin : g_index
      assign bit_out = tbl[sel];
   end
endmodule

// File: rtl/lcell_ff.sv
`timescale 1ns/1ps
// Storage flip-flop with load enable, synchronous reset and hold-off.
module lcell_ff #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_off,
   input  logic en,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst || hold_off) begin
         q <= RST_VAL;
      end else if (en) begin
         q <= d;
      end
   end

   // R5: without enable the state stays put
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!en && !hold_off) |=> (q == $past(q)));

   // R5: with enable the data is captured
   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      (en && !hold_off) |=> (q == $past(d)));

   // R8: hold-off forces the reset value
   p_off_r8: assert property (@(posedge clk) disable iff (rst)
      hold_off |=> (q == RST_VAL));
endmodule

// File: rtl/lcell_outsel.sv
`timescale 1ns/1ps
// Combines the two lookups per mode and chooses register or direct per output.
module lcell_outsel
   import lcell_pkg::*;
(
   input  d_mode_e                  mode,
   input  lut_pair_t                luts,
   input  logic                     d_bit,
   input  logic                     ff_q,
   input  logic [LC_NUM_OUT-1:0]    reg_sel,
   output logic                     fn_d,
   output logic [LC_NUM_OUT-1:0]    y
);
   logic                  merged;
   logic [LC_NUM_OUT-1:0] fn;

   always_comb begin
      merged = d_bit ? luts.hi : luts.lo;
      if (mode == DM_SELECT) begin
         fn = {LC_NUM_OUT{merged}};
      end else begin
         fn = {luts.hi, luts.lo};
      end
   end

   assign fn_d = fn[0];

   for (genvar k = 0; k < LC_NUM_OUT; k++) begin : g_out
      assign y[k] = reg_sel[k] ? ff_q : fn[k];
   end
endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
// Programmable logic cell: two lookup tables, one flip-flop, two outputs.
module cfg_logic_cell
   import lcell_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter bit          TREE_MUX = 1'b1,
   parameter bit          RST_VAL  = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [SEL_W:0]           sig_in,
   input  logic [(1<<SEL_W)-1:0]    cfg_tbl_lo,
   input  logic [(1<<SEL_W)-1:0]    cfg_tbl_hi,
   input  logic                     cfg_merge,
   input  logic [1:0]               cfg_out_reg,
   input  logic                     cfg_ff_off,
   output logic [1:0]               cell_out
);
   localparam int unsigned DEPTH = 1 << SEL_W;

   if (LC_NUM_OUT != 2) begin : g_bad_out
      $error("cfg_logic_cell: port list assumes two outputs");
   end

   logic [SEL_W-1:0] sel;
   logic             d_bit;
   d_mode_e          mode;
   lut_pair_t        luts;
   logic             fn_d;
   logic             ff_en;
   logic             ff_q;

   assign sel   = sig_in[SEL_W-1:0];
   assign d_bit = sig_in[SEL_W];
   assign mode  = d_mode_e'(cfg_merge);
   assign ff_en = (mode == DM_SELECT) || d_bit;

   lcell_lut #(.SEL_W(SEL_W), .TREE_MUX(TREE_MUX)) u_lut_lo (
      .tbl(cfg_tbl_lo), .sel(sel), .bit_out(luts.lo)
   );

   lcell_lut #(.SEL_W(SEL_W), .TREE_MUX(TREE_MUX)) u_lut_hi (
      .tbl(cfg_tbl_hi), .sel(sel), .bit_out(luts.hi)
   );

   lcell_outsel u_outsel (
      .mode(mode), .luts(luts), .d_bit(d_bit), .ff_q(ff_q),
      .reg_sel(cfg_out_reg), .fn_d(fn_d), .y(cell_out)
   );

   lcell_ff #(.RST_VAL(RST_VAL)) u_ff (
      .clk(clk), .rst(rst), .hold_off(cfg_ff_off),
      .en(ff_en), .d(fn_d), .q(ff_q)
   );

   // R1: first output follows the low table in split mode
   p_split_lo_r1: assert property (@(posedge clk) disable iff (rst)
      (!cfg_merge && !cfg_out_reg[0]) |-> (cell_out[0] == cfg_tbl_lo[sel]));

   // R2: second output follows the high table in split mode
   p_split_hi_r2: assert property (@(posedge clk) disable iff (rst)
      (!cfg_merge && !cfg_out_reg[1]) |-> (cell_out[1] == cfg_tbl_hi[sel]));

   // R3: in merged mode both direct outputs give the same function
   p_merge_same_r3: assert property (@(posedge clk) disable iff (rst)
      (cfg_merge && cfg_out_reg == 2'b00) |-> (cell_out[0] == cell_out[1]));

   // R4: registered outputs show the flip-flop
   p_regsel0_r4: assert property (@(posedge clk) disable iff (rst)
      cfg_out_reg[0] |-> (cell_out[0] == ff_q));
   p_regsel1_r4: assert property (@(posedge clk) disable iff (rst)
      cfg_out_reg[1] |-> (cell_out[1] == ff_q));

   // R6: merged mode loads on every edge, ignoring the enable role
   p_merge_load_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_merge && !cfg_ff_off) |=> (ff_q == $past(fn_d)));
endmodule

// File: tb/cfg_logic_cell_test.sv
`timescale 1ns/1ps
module cfg_logic_cell_test;
   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] sig_in;
   logic [7:0] cfg_tbl_lo, cfg_tbl_hi;
   logic       cfg_merge;
   logic [1:0] cfg_out_reg;
   logic       cfg_ff_off;
   logic [1:0] cell_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   logic qm;

   always #2.5 clk = ~clk;   // 200 MHz

   cfg_logic_cell uut (
      .clk(clk), .rst(rst), .sig_in(sig_in),
      .cfg_tbl_lo(cfg_tbl_lo), .cfg_tbl_hi(cfg_tbl_hi),
      .cfg_merge(cfg_merge), .cfg_out_reg(cfg_out_reg),
      .cfg_ff_off(cfg_ff_off), .cell_out(cell_out)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: in=%b got %b expected %b at %0t", req, sig_in, got, exp, $time);
      end
   endtask

   function automatic logic merged_fn(input logic [7:0] lo, input logic [7:0] hi,
                                      input logic [3:0] v);
      return v[3] ? hi[v[2:0]] : lo[v[2:0]];
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; sig_in = 4'hF; cfg_tbl_lo = 8'hFF; cfg_tbl_hi = 8'hFF;
      cfg_merge = 1'b1; cfg_out_reg = 2'b11; cfg_ff_off = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: reset clears the flip-flop despite a pending load
      chk("R7 reset out0", cell_out[0], 1'b0);
      chk("R7 reset out1", cell_out[1], 1'b0);
      rst = 1'b0;

      // R1 R2 R3: exhaustive combinational sweep
      cfg_out_reg = 2'b00;
      for (int t = 0; t < 12; t++) begin
         cfg_tbl_lo = 8'(t * 73) ^ 8'h5A;
         cfg_tbl_hi = 8'(t * 151 + 7);
         if (t == 0) begin cfg_tbl_lo = 8'h00; cfg_tbl_hi = 8'hFF; end
         for (int m = 0; m < 2; m++) begin
            cfg_merge = m[0];
            for (int v = 0; v < 16; v++) begin
               @(negedge clk);
               sig_in = 4'(v);
               #1;
               if (m == 0) begin
                  chk("R1 split low", cell_out[0], cfg_tbl_lo[v[2:0]]);
                  chk("R2 split high", cell_out[1], cfg_tbl_hi[v[2:0]]);
               end else begin
                  chk("R3 merged out0", cell_out[0], merged_fn(cfg_tbl_lo, cfg_tbl_hi, 4'(v)));
                  chk("R3 merged out1", cell_out[1], merged_fn(cfg_tbl_lo, cfg_tbl_hi, 4'(v)));
               end
            end
         end
      end

      // R5 R4: split mode, enable gating, out0 registered and out1 direct
      cfg_merge = 1'b0; cfg_out_reg = 2'b01;
      cfg_tbl_lo = 8'b1011_0110; cfg_tbl_hi = 8'b0101_1100;
      @(negedge clk); sig_in = 4'b1000;   // load lo[0]=0
      @(posedge clk); qm = cfg_tbl_lo[0];
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         sig_in = 4'((i * 7 + 3) & 15);
         @(posedge clk);
         if (sig_in[3]) qm = cfg_tbl_lo[sig_in[2:0]];
         #1;
         chk("R5 enable gated load", cell_out[0], qm);
         chk("R4 other output direct", cell_out[1], cfg_tbl_hi[sig_in[2:0]]);
      end

      // R6 R4: merged mode loads every edge, out1 registered
      cfg_merge = 1'b1; cfg_out_reg = 2'b10;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         sig_in = 4'((i * 11 + 5) & 15);
         @(posedge clk);
         qm = merged_fn(cfg_tbl_lo, cfg_tbl_hi, sig_in);
         #1;
         chk("R6 merged load", cell_out[1], qm);
         chk("R4 out0 direct merged", cell_out[0], qm);
      end

      // R8: hold-off keeps state cleared
      cfg_tbl_lo = 8'hFF; cfg_tbl_hi = 8'hFF; cfg_out_reg = 2'b11;
      @(negedge clk); cfg_ff_off = 1'b1; sig_in = 4'hF;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk("R8 hold-off out0", cell_out[0], 1'b0);
         chk("R8 hold-off out1", cell_out[1], 1'b0);
      end
      @(negedge clk); cfg_ff_off = 1'b0;
      @(posedge clk); #1;
      chk("R6 load after hold-off release", cell_out[0], 1'b1);

      // R7: synchronous reset wins over enabled load
      @(negedge clk); rst = 1'b1;
      #1;
      chk("R7 reset is synchronous", cell_out[0], 1'b1);
      @(posedge clk); #1;
      chk("R7 reset clears", cell_out[0], 1'b0);
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #1;
      chk("R6 loads again after reset", cell_out[1], 1'b1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule